// File: doc/BRIEF.md
# Branch Target Prediction Buffer

This block sits next to the fetch stage of an instruction pipeline and guesses where fetch goes next. It keeps a small direct-mapped table, with one entry per slot chosen from the low bits of a branch's program counter. Each entry holds a valid flag, an address tag, the direction the branch took the last time it resolved, and the signed displacement to its target. In every cycle the fetch address is looked up without a clock delay. A hit whose stored direction is taken steers fetch to the address plus the stored displacement. Any other case continues sequentially at the address plus four.

Later in the pipe the branch unit resolves each branch. It returns the real direction and displacement, and with them the prediction that fetch acted on. When the two disagree, the block raises a flush in that same cycle and puts the corrected address on the next-fetch output. The table entry is written on the following clock edge. A taken branch that has no entry claims its slot and evicts whatever was there. A not-taken branch without an entry leaves the table untouched.

Both the fetch lookup and the resolve report are valid-qualified. There is no ready signal: the block accepts one lookup and one resolve in every cycle, so it never exerts back-pressure on either side.

Top module: `branch_target_buf`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (`pred_hit`=0, `pred_taken`=0) and `next_pc` is `fetch_pc`+4.
- R2: With no flush, a lookup that misses, or any cycle with `fetch_valid`=0, gives `pred_hit`=0, `pred_taken`=0 and `next_pc` = `fetch_pc`+4.
- R3: A hit whose stored direction is taken gives `pred_hit`=1, `pred_taken`=1 and `next_pc` = `fetch_pc` + the sign-extended stored displacement.
- R4: A hit whose stored direction is not taken gives `pred_hit`=1, `pred_taken`=0 and `next_pc` = `fetch_pc`+4.
- R5: The slot is `fetch_pc[5:2]`, and the tag is `fetch_pc[31:6]`. A lookup hits only when the slot is valid and its tag is equal, so two addresses that share bits [5:2] but differ above them do not alias.
- R6: A resolved taken branch without an entry allocates its slot with direction taken and its displacement, and it replaces the previous occupant, which then misses.
- R7: A resolved not-taken branch without an entry writes nothing, so it still misses afterwards.
- R8: A resolved branch that has an entry overwrites the stored direction and displacement with the new outcome.
- R9: A mispredict is detected when `resolve_valid`=1 and either `resolve_pred_taken` differs from `resolve_taken`, or both are 1 and `resolve_pred_off` differs from `resolve_off`. In that case `flush`=1 in the same cycle, and `redirect_pc` is `resolve_pc`+displacement if taken, else `resolve_pc`+4. In every other case `flush`=0.
- R10: While `flush`=1, `next_pc` equals `redirect_pc`, whatever the lookup result.
- R11: A table write takes effect at the clock edge that ends the resolve cycle. A lookup in that same cycle, to the same slot, sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Lookup found a matching entry |
| pred_taken | output | 1 | Lookup predicts taken |
| next_pc | output | 32 | Address to fetch next |
| resolve_valid | input | 1 | A branch outcome is reported this cycle |
| resolve_pc | input | 32 | Address of the resolved branch |
| resolve_taken | input | 1 | Actual direction |
| resolve_off | input | 16 | Actual signed target displacement |
| resolve_pred_taken | input | 1 | Direction that was predicted for it |
| resolve_pred_off | input | 16 | Displacement that was predicted for it |
| flush | output | 1 | Mispredict: discard wrong-path instructions |
| redirect_pc | output | 32 | Corrected fetch address |

## Verification
A lookup and a resolve can arrive in the same cycle. The bench provokes this by pointing both at the same slot, sometimes with a matching tag and sometimes with an aliasing one. It expects the lookup to report the table as it stood before the edge, and it expects a mispredict in that cycle to override the predicted `next_pc` with `redirect_pc`. A reference table in the bench is updated only after each cycle's expectations are formed, and the following lookup then confirms that the write has landed.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned BTB_PC_W  = 32;
  localparam int unsigned BTB_IDX_W = 4;
  localparam int unsigned BTB_OFF_W = 16;

  // Kind of table write a resolved branch causes
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_REFRESH = 2'd1,
    WR_ALLOC   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  // fetch read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_taken,
  output logic [OFF_W-1:0] rd_off,
  // resolve probe port
  input  logic [IDX_W-1:0] pr_idx,
  output logic             pr_valid,
  output logic [TAG_W-1:0] pr_tag,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_taken,
  input  logic [OFF_W-1:0] wr_off
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic             vld_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic             dir_q [ENTRIES];
  logic [OFF_W-1:0] off_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[e] <= 1'b0;
      else if (sel) vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag;
        dir_q[e] <= wr_taken;
        off_q[e] <= wr_off;
      end
    end
  end

  // Reads come from registers, so a same-cycle write is not visible yet
  always_comb begin
    rd_valid = vld_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_taken = dir_q[rd_idx];
    rd_off   = off_q[rd_idx];
    pr_valid = vld_q[pr_idx];
    pr_tag   = tag_q[pr_idx];
  end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFF_W = 16,
  localparam int unsigned TAG_W = PC_W - IDX_W - 2
) (
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_taken,
  input  logic [OFF_W-1:0] rd_off,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  pred_pc
);
  logic [PC_W-1:0] disp;

  assign disp    = {{(PC_W-OFF_W){rd_off[OFF_W-1]}}, rd_off};
  assign hit     = fetch_valid && rd_valid && (rd_tag == fetch_pc[PC_W-1:IDX_W+2]);
  assign taken   = hit && rd_taken;
  assign pred_pc = taken ? (fetch_pc + disp) : (fetch_pc + PC_W'(4));
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFF_W = 16,
  localparam int unsigned TAG_W = PC_W - IDX_W - 2
) (
  input  logic             resolve_valid,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_taken,
  input  logic [OFF_W-1:0] resolve_off,
  input  logic             resolve_pred_taken,
  input  logic [OFF_W-1:0] resolve_pred_off,
  input  logic             pr_valid,
  input  logic [TAG_W-1:0] pr_tag,
  output logic             mispredict,
  output logic [PC_W-1:0]  fix_pc,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic             wr_taken,
  output logic [OFF_W-1:0] wr_off
);
  logic     dir_wrong, tgt_wrong, present;
  wr_kind_e kind;
  logic [PC_W-1:0] disp;

  assign disp      = {{(PC_W-OFF_W){resolve_off[OFF_W-1]}}, resolve_off};
  assign dir_wrong = resolve_pred_taken != resolve_taken;
  assign tgt_wrong = resolve_taken && resolve_pred_taken && (resolve_pred_off != resolve_off);
  assign mispredict = resolve_valid && (dir_wrong || tgt_wrong);
  assign fix_pc    = resolve_taken ? (resolve_pc + disp) : (resolve_pc + PC_W'(4));

  assign present = pr_valid && (pr_tag == resolve_pc[PC_W-1:IDX_W+2]);

  always_comb begin
    kind = WR_NONE;
    if (resolve_valid) begin
      if (present)            kind = WR_REFRESH;
      else if (resolve_taken) kind = WR_ALLOC;
    end
  end

  assign wr_en    = kind != WR_NONE;
  assign wr_idx   = resolve_pc[IDX_W+1:2];
  assign wr_tag   = resolve_pc[PC_W-1:IDX_W+2];
  assign wr_taken = resolve_taken;
  assign wr_off   = resolve_off;
endmodule

// File: rtl/branch_target_buf.sv
module branch_target_buf #(
  parameter int unsigned PC_W  = btb_pkg::BTB_PC_W,
  parameter int unsigned IDX_W = btb_pkg::BTB_IDX_W,
  parameter int unsigned OFF_W = btb_pkg::BTB_OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             pred_hit,
  output logic             pred_taken,
  output logic [PC_W-1:0]  next_pc,
  input  logic             resolve_valid,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_taken,
  input  logic [OFF_W-1:0] resolve_off,
  input  logic             resolve_pred_taken,
  input  logic [OFF_W-1:0] resolve_pred_off,
  output logic             flush,
  output logic [PC_W-1:0]  redirect_pc
);
  localparam int unsigned TAG_W = PC_W - IDX_W - 2;

  logic             rd_valid, rd_taken, pr_valid;
  logic [TAG_W-1:0] rd_tag, pr_tag;
  logic [OFF_W-1:0] rd_off;
  logic             wr_en, wr_taken;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [OFF_W-1:0] wr_off;
  logic [PC_W-1:0]  pred_pc;

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_pc[IDX_W+1:2]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_taken (rd_taken),
    .rd_off   (rd_off),
    .pr_idx   (resolve_pc[IDX_W+1:2]),
    .pr_valid (pr_valid),
    .pr_tag   (pr_tag),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_taken (wr_taken),
    .wr_off   (wr_off)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_lookup (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .rd_valid    (rd_valid),
    .rd_tag      (rd_tag),
    .rd_taken    (rd_taken),
    .rd_off      (rd_off),
    .hit         (pred_hit),
    .taken       (pred_taken),
    .pred_pc     (pred_pc)
  );

  btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_resolve (
    .resolve_valid      (resolve_valid),
    .resolve_pc         (resolve_pc),
    .resolve_taken      (resolve_taken),
    .resolve_off        (resolve_off),
    .resolve_pred_taken (resolve_pred_taken),
    .resolve_pred_off   (resolve_pred_off),
    .pr_valid           (pr_valid),
    .pr_tag             (pr_tag),
    .mispredict         (flush),
    .fix_pc             (redirect_pc),
    .wr_en              (wr_en),
    .wr_idx             (wr_idx),
    .wr_tag             (wr_tag),
    .wr_taken           (wr_taken),
    .wr_off             (wr_off)
  );

  // A mispredict outranks the fresh guess
  assign next_pc = flush ? redirect_pc : pred_pc;
endmodule

// File: rtl/branch_target_buf_chk.sv
module branch_target_buf_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             pred_hit,
  input logic             pred_taken,
  input logic [PC_W-1:0]  next_pc,
  input logic             resolve_valid,
  input logic [PC_W-1:0]  resolve_pc,
  input logic             resolve_taken,
  input logic [OFF_W-1:0] resolve_off,
  input logic             resolve_pred_taken,
  input logic [OFF_W-1:0] resolve_pred_off,
  input logic             flush,
  input logic [PC_W-1:0]  redirect_pc
);
  p_idle_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!pred_hit && !pred_taken));

  p_seq_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !pred_hit) |-> (next_pc == fetch_pc + PC_W'(4)));

  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  p_nt_hit_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pred_hit && !pred_taken) |-> (next_pc == fetch_pc + PC_W'(4)));

  p_alloc_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(resolve_valid && resolve_taken) && (fetch_pc == $past(resolve_pc)))
      |-> (pred_hit && pred_taken));

  p_flush_from_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> resolve_valid);

  p_flush_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (next_pc == redirect_pc));
endmodule

bind branch_target_buf branch_target_buf_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/branch_target_buf_bench.sv
`timescale 1ns/1ps
module branch_target_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken, flush;
  logic [31:0] next_pc, redirect_pc;
  logic        resolve_valid = 1'b0;
  logic [31:0] resolve_pc = '0;
  logic        resolve_taken = 1'b0;
  logic [15:0] resolve_off = '0;
  logic        resolve_pred_taken = 1'b0;
  logic [15:0] resolve_pred_off = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_target_buf u_branch_target_buf (.*);

  typedef struct {
    string       req;
    logic        hit;
    logic        taken;
    logic [31:0] nxt;
    logic        fl;
    logic [31:0] red;
  } exp_t;
  exp_t q[$];

  // reference table, driven only by the requirements
  logic        m_v [16];
  logic [25:0] m_t [16];
  logic        m_d [16];
  logic [15:0] m_o [16];

  function automatic logic [31:0] sx(input logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  task automatic step(input string req, input logic fv, input logic [31:0] fpc,
                      input logic rv, input logic [31:0] rpc, input logic rt,
                      input logic [15:0] ro, input logic rpt, input logic [15:0] rpo);
    exp_t e;
    logic [3:0] fi, ri;
    logic rhit;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc;
    resolve_valid = rv; resolve_pc = rpc; resolve_taken = rt;
    resolve_off = ro; resolve_pred_taken = rpt; resolve_pred_off = rpo;
    fi = fpc[5:2];
    e.req   = req;
    e.hit   = fv && m_v[fi] && (m_t[fi] == fpc[31:6]);
    e.taken = e.hit && m_d[fi];
    e.fl    = rv && ((rpt != rt) || (rt && rpt && (rpo != ro)));
    e.red   = rt ? rpc + sx(ro) : rpc + 32'd4;
    e.nxt   = e.fl ? e.red : (e.taken ? fpc + sx(m_o[fi]) : fpc + 32'd4);
    q.push_back(e);
    // table write lands at the coming edge (R11)
    ri = rpc[5:2];
    rhit = m_v[ri] && (m_t[ri] == rpc[31:6]);
    if (rv && (rhit || rt)) begin
      m_v[ri] = 1'b1; m_t[ri] = rpc[31:6]; m_d[ri] = rt; m_o[ri] = ro;
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc);
    step(req, 1'b1, pc, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic res(input string req, input logic [31:0] fpc, input logic [31:0] rpc,
                     input logic rt, input logic [15:0] ro, input logic rpt, input logic [15:0] rpo);
    step(req, 1'b1, fpc, 1'b1, rpc, rt, ro, rpt, rpo);
  endtask

  // monitor: compare each queued expectation against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pred_hit !== e.hit || pred_taken !== e.taken || next_pc !== e.nxt ||
            flush !== e.fl || (e.fl && redirect_pc !== e.red)) begin
          errors++;
          $display("FAIL %s: got hit=%b tk=%b next=%h flush=%b redir=%h exp hit=%b tk=%b next=%h flush=%b redir=%h",
                   e.req, pred_hit, pred_taken, next_pc, flush, redirect_pc,
                   e.hit, e.taken, e.nxt, e.fl, e.red);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 1'b0; m_t[i] = '0; m_d[i] = 1'b0; m_o[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look("R1", 32'h0000_0100);
    look("R1", 32'h0000_0200);
    // R7: not-taken miss allocates nothing
    res("R7", 32'h0000_0300, 32'h0000_0200, 1'b0, 16'h0040, 1'b0, 16'h0000);
    look("R7", 32'h0000_0200);
    // R6 R9 R11: taken miss allocates; same-cycle lookup sees old state
    res("R11", 32'h0000_0200, 32'h0000_0200, 1'b1, 16'h0040, 1'b0, 16'h0000);
    look("R3", 32'h0000_0200);
    // R8 R9: direction flips to not taken
    res("R8", 32'h0000_0200, 32'h0000_0200, 1'b0, 16'h0040, 1'b1, 16'h0040);
    look("R4", 32'h0000_0200);
    // R9: taken again, then target moves backwards
    res("R9", 32'h0000_0104, 32'h0000_0200, 1'b1, 16'h0040, 1'b0, 16'h0000);
    res("R9", 32'h0000_0200, 32'h0000_0200, 1'b1, 16'hFFE0, 1'b1, 16'h0040);
    look("R3", 32'h0000_0200);
    // R5: alias shares slot 0 with a different tag
    look("R5", 32'h0000_0600);
    res("R6", 32'h0000_0600, 32'h0000_0600, 1'b1, 16'h0008, 1'b0, 16'h0000);
    look("R6", 32'h0000_0200);
    look("R6", 32'h0000_0600);
    // R9 correct prediction gives no flush; R10 flush overrides a hit
    res("R9", 32'h0000_0600, 32'h0000_0600, 1'b1, 16'h0008, 1'b1, 16'h0008);
    res("R10", 32'h0000_0600, 32'h0000_0a04, 1'b1, 16'h0010, 1'b0, 16'h0000);
    look("R3", 32'h0000_0a04);
    // R2: lookup disabled
    step("R2", 1'b0, 32'h0000_0600, 1'b0, 32'h0, 1'b0, 16'h0, 1'b0, 16'h0);
    look("R2", 32'h0000_0700);

    repeat (3) @(negedge clk);
    done = 1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending exp 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule